// File: doc/BRIEF.md
# Buffered-Reload Pulse Train Timer

This block generates a train of pulses. An external feeder sets the length of each half-period, one value at a time. A prescaler divides the clock. The divided tick drives an up-counter that runs from zero to an active reload value and then wraps. A single compare channel flips `pulse_out` whenever the counter lands on the compare value.

Every compare event asks the feeder for one more reload word over a valid/ready data port. The word is stored in the reload register. When reload buffering is on, the word only becomes the active period at the next wrap. Each half-period of the output can therefore differ. A word of zero stops the train.

Software reaches four word registers through a plain write port with byte strobes:

| Address | Register |
| --- | --- |
| 0 | control |
| 1 | prescaler |
| 2 | reload |
| 3 | compare |

Back-pressure on the feed port works as follows:
- `feed_ready` is the request.
- A word moves only in a cycle where `feed_valid` and `feed_ready` are both high.
- The feeder may hold `feed_valid` high for as long as it likes. Nothing is taken while `feed_ready` is low.
- The block never withdraws `feed_ready` until a word has been taken.

Top module: `pulse_train_timer`

## Requirements
- R1: The counter advances once every PSC+1 clocks, where PSC is the prescaler register (address 1, low 16 bits). A new prescaler value becomes active only at a wrap or a software update.
- R2: The counter counts from 0 up to the active reload value, then returns to 0. That wrap is the update event.
- R3: When control bit 1 (reload buffering) is set, a reload write goes to a shadow copy and becomes active at the next wrap. When the bit is clear, the write takes effect at once.
- R4: `pulse_out` toggles in the cycle the counter reaches the compare register (address 3). With compare 0, the toggle falls at each wrap.
- R5: Each compare event raises `feed_ready`. A word taken while `feed_valid` and `feed_ready` are both high is written to the reload register following R3, and `feed_ready` then drops.
- R6: Only one request is open at a time. A compare event while a request is still open sets `overrun`, which stays set until reset.
- R7: An active reload of 0 halts the train. The counter rests at 0, `pulse_out` stops changing, and no further requests are raised.
- R8: Writing control (address 0) with bit 2 set performs a software update. The shadow reload and prescaler values are copied to the active registers, and the counter and prescaler are cleared in that same cycle. The bit does not stay set.
- R9: While control bit 0 (count enable) is clear, the counter and prescaler hold and `pulse_out` keeps its level.
- R10: The reload and compare registers are 32 bits wide and updated byte by byte. `cfg_strb[i]` enables bits 8i+7..8i. A write with no strobe bit set changes nothing.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 prescaler, 2 reload, 3 compare |
| cfg_wdata | input | 32 | Register write data |
| cfg_strb | input | 4 | Byte enables for the write |
| feed_valid | input | 1 | Feeder offers a reload word |
| feed_data | input | 32 | Reload word from the feeder |
| feed_ready | output | 1 | Request open; a word is taken when valid is also high |
| pulse_out | output | 1 | Toggling pulse output |
| overrun | output | 1 | Sticky flag: compare event while a request was open |
| count | output | 32 | Current counter value |

## Verification
The main feed path is driven with a word sequence that mixes long and short periods and ends in zero, with a prescaler above one. The scoreboard measures each toggle-to-toggle gap. This separates a period that takes its word one wrap late (buffered) from one that takes it at once, and it shows that the divider multiplies every gap. With buffering off, the peak counter value shows whether a write acts at once, whether an unstrobed write is dropped, and whether a single-byte write merges into the old word rather than replacing it. A nonzero compare value is checked by sampling the counter at each toggle. Separate windows with the feeder silent, and with counting disabled, expose the overrun flag and the held output.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PSC    = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_CMP    = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_PRE_BIT = 1;
  localparam int unsigned CTRL_UG_BIT  = 2;
endpackage

// File: rtl/ptt_regs.sv
module ptt_regs
  import ptt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 16,
  localparam int unsigned STRB_W = CNT_W / 8,
  localparam int unsigned PSC_B  = PSC_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic              feed_acc_i,
  input  logic [CNT_W-1:0]  feed_data_i,
  output logic              en_o,
  output logic              pre_o,
  output logic              ug_o,
  output logic [PSC_W-1:0]  psc_sh_o,
  output logic [CNT_W-1:0]  arr_sh_o,
  output logic [CNT_W-1:0]  arr_nx_o,
  output logic              arr_wr_o,
  output logic [CNT_W-1:0]  cmp_o
);
  reg_sel_e sel;
  logic     wr_rel, wr_cmp, wr_psc, wr_ctl;

  assign sel    = reg_sel_e'(addr_i);
  assign wr_ctl = we_i && (sel == SEL_CTRL) && strb_i[0];
  assign wr_psc = we_i && (sel == SEL_PSC);
  assign wr_rel = we_i && (sel == SEL_RELOAD) && (|strb_i);
  assign wr_cmp = we_i && (sel == SEL_CMP);
  assign ug_o   = wr_ctl && wdata_i[CTRL_UG_BIT];
  assign arr_wr_o = wr_rel || feed_acc_i;

  always_comb begin
    arr_nx_o = arr_sh_o;
    if (feed_acc_i) begin
      arr_nx_o = feed_data_i;
    end else begin
      for (int b = 0; b < int'(STRB_W); b++)
        if (strb_i[b]) arr_nx_o[b*8 +: 8] = wdata_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o     <= 1'b0;
      pre_o    <= 1'b0;
      psc_sh_o <= '0;
      arr_sh_o <= '0;
      cmp_o    <= '0;
    end else begin
      if (wr_ctl) begin
        en_o  <= wdata_i[CTRL_EN_BIT];
        pre_o <= wdata_i[CTRL_PRE_BIT];
      end
      if (wr_psc)
        for (int b = 0; b < int'(PSC_B); b++)
          if (strb_i[b]) psc_sh_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      if (wr_cmp)
        for (int b = 0; b < int'(STRB_W); b++)
          if (strb_i[b]) cmp_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      if (arr_wr_o) arr_sh_o <= arr_nx_o;
    end
  end
endmodule

// File: rtl/ptt_prescale.sv
module ptt_prescale #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ug_i,
  input  logic             upd_i,
  input  logic [PSC_W-1:0] psc_sh_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q, pact_q;

  assign tick_o = en_i && (pcnt_q == pact_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      pact_q <= '0;
    end else if (ug_i) begin
      pcnt_q <= '0;
      pact_q <= psc_sh_i;
    end else begin
      if (en_i) pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
      if (upd_i) pact_q <= psc_sh_i;
    end
  end

  // R1
  psc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= pact_q);
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             ug_i,
  input  logic             pre_i,
  input  logic             arr_wr_i,
  input  logic [CNT_W-1:0] arr_nx_i,
  input  logic [CNT_W-1:0] arr_sh_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             upd_o,
  output logic             evt_o,
  output logic             halted_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] arr_q, cnt_nx;
  logic             wrap;

  assign halted_o = (arr_q == '0);
  assign wrap     = (cnt_o >= arr_q);
  assign cnt_nx   = wrap ? '0 : cnt_o + 1'b1;
  assign upd_o    = tick_i && !halted_o && wrap;
  assign evt_o    = tick_i && !halted_o && (cnt_nx == cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      arr_q <= '0;
    end else begin
      if (ug_i)        cnt_o <= '0;
      else if (tick_i) cnt_o <= halted_o ? '0 : cnt_nx;
      if (arr_wr_i && !pre_i)  arr_q <= arr_nx_i;
      else if (ug_i || upd_o)  arr_q <= arr_sh_i;
    end
  end

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ug_i) |=> $stable(cnt_o));
  // R8
  ug_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ug_i |=> (cnt_o == '0));
endmodule

// File: rtl/ptt_feed.sv
module ptt_feed (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic valid_i,
  output logic ready_o,
  output logic acc_o,
  output logic ovr_o
);
  assign acc_o = valid_i && ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (evt_i)      ready_o <= 1'b1;
      else if (acc_o) ready_o <= 1'b0;
      if (evt_i && ready_o && !acc_o) ovr_o <= 1'b1;
    end
  end

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && ready_o && !valid_i) |=> ovr_o);
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o);
  // R5
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o && !evt_i) |=> !ready_o);
endmodule

// File: rtl/pulse_train_timer.sv
module pulse_train_timer #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 16,
  localparam int unsigned STRB_W = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [STRB_W-1:0] cfg_strb,
  input  logic              feed_valid,
  input  logic [CNT_W-1:0]  feed_data,
  output logic              feed_ready,
  output logic              pulse_out,
  output logic              overrun,
  output logic [CNT_W-1:0]  count
);
  logic             en, pre, ug, arr_wr, tick, upd, evt, halted, acc;
  logic [PSC_W-1:0] psc_sh;
  logic [CNT_W-1:0] arr_sh, arr_nx, cmp;

  ptt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .strb_i(cfg_strb), .feed_acc_i(acc),
    .feed_data_i(feed_data), .en_o(en), .pre_o(pre), .ug_o(ug),
    .psc_sh_o(psc_sh), .arr_sh_o(arr_sh), .arr_nx_o(arr_nx),
    .arr_wr_o(arr_wr), .cmp_o(cmp));

  ptt_prescale #(.PSC_W(PSC_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ug_i(ug), .upd_i(upd),
    .psc_sh_i(psc_sh), .tick_o(tick));

  ptt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick), .ug_i(ug),
    .pre_i(pre), .arr_wr_i(arr_wr), .arr_nx_i(arr_nx), .arr_sh_i(arr_sh),
    .cmp_i(cmp), .upd_o(upd), .evt_o(evt), .halted_o(halted), .cnt_o(count));

  ptt_feed feed_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .valid_i(feed_valid),
    .ready_o(feed_ready), .acc_o(acc), .ovr_o(overrun));

  always_ff @(posedge clk) begin
    if (!rst_n)   pulse_out <= 1'b0;
    else if (evt) pulse_out <= ~pulse_out;
  end

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ug) |=> $stable(pulse_out));
  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ug) |=> $stable(pulse_out));
endmodule

// File: tb/pulse_train_timer_tb.sv
module pulse_train_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_strb = '0;
  logic        feed_valid = 1'b0;
  logic [31:0] feed_data = '0;
  logic        feed_ready, pulse_out, overrun;
  logic [31:0] count;

  always #2.5 clk = ~clk;

  pulse_train_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_strb(cfg_strb), .feed_valid(feed_valid),
    .feed_data(feed_data), .feed_ready(feed_ready), .pulse_out(pulse_out),
    .overrun(overrun), .count(count));

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0, last_t = 0;
  int exp_q[$];
  bit sb_on = 0, have_ref = 0, cmp_win = 0, max_on = 0, feeder_on = 0;
  logic prev_pulse = 1'b0;
  int hits = 0, hits_bad = 0, fidx = 0;
  longint maxc = 0;
  int vals[4] = '{3, 1, 5, 0};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_strb = s;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; cfg_strb = '0;
  endtask

  task automatic push_exp(input int reload, input int psc);
    exp_q.push_back((reload + 1) * (psc + 1));
  endtask

  // monitor: scoreboard of toggle-to-toggle gaps
  always @(negedge clk) begin
    cyc++;
    if (pulse_out !== prev_pulse) begin
      prev_pulse = pulse_out;
      if (sb_on) begin
        if (have_ref) begin
          if (exp_q.size() == 0) chk(0, "R7 toggle after halt", cyc - last_t, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            chk((cyc - last_t) == e, "R1 R3 R5 gap", cyc - last_t, e);
          end
        end
        have_ref = 1; last_t = cyc;
      end
      if (cmp_win) begin
        hits++;
        if (count != 32'd2) hits_bad++;
      end
    end
    if (max_on && count > maxc) maxc = count;
  end

  // feeder
  always @(negedge clk) begin
    if (feeder_on) begin
      if (feed_valid) begin
        feed_valid = 1'b0; fidx++;
      end else if (feed_ready && fidx < 4) begin
        feed_valid = 1'b1; feed_data = vals[fidx];
      end
    end
  end

  initial begin
    #(5 * 20000);
    chk(0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0, "R2 reset count", count, 0);
    chk(pulse_out == 0, "R4 reset pulse", pulse_out, 0);
    chk(feed_ready == 0, "R5 reset request", feed_ready, 0);
    chk(overrun == 0, "R6 reset overrun", overrun, 0);

    // fed train: prescaler 2, start reload 2, then words 3,1,5,0
    wr(2'd0, 32'h2, 4'hF);
    wr(2'd1, 32'd2, 4'hF);
    wr(2'd2, 32'd2, 4'hF);
    wr(2'd3, 32'd0, 4'hF);
    wr(2'd0, 32'h6, 4'hF);
    push_exp(2, 2); push_exp(3, 2); push_exp(1, 2); push_exp(5, 2);
    sb_on = 1; feeder_on = 1;
    wr(2'd0, 32'h3, 4'hF);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all gaps seen", exp_q.size(), 0);
    repeat (60) @(negedge clk);
    chk(count == 0, "R7 halted count", count, 0);
    chk(feed_ready == 1, "R5 request after last event", feed_ready, 1);
    chk(overrun == 0, "R6 no overrun when fed", overrun, 0);
    sb_on = 0; feeder_on = 0;

    // R6: restart with feeder silent
    wr(2'd2, 32'd3, 4'hF);
    wr(2'd0, 32'h6, 4'hF);
    wr(2'd0, 32'h3, 4'hF);
    repeat (40) @(negedge clk);
    chk(overrun == 1, "R6 overrun set", overrun, 1);

    // R9: counting disabled holds everything
    wr(2'd0, 32'h2, 4'hF);
    begin
      logic [31:0] c0; logic p0;
      c0 = count; p0 = pulse_out;
      repeat (30) @(negedge clk);
      chk(count == c0, "R9 count held", count, c0);
      chk(pulse_out == p0, "R9 pulse held", pulse_out, p0);
    end

    // R3 direct reload with buffering off, prescaler 0
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd1, 32'd0, 4'hF);
    wr(2'd2, 32'd3, 4'hF);
    wr(2'd0, 32'h4, 4'hF);
    chk(count == 0, "R8 update clears counter", count, 0);
    wr(2'd0, 32'h1, 4'hF);
    maxc = 0; max_on = 1;
    repeat (40) @(negedge clk);
    chk(maxc == 3, "R2 R3 peak count", maxc, 3);

    // R10: no strobes -> ignored
    wr(2'd2, 32'd9, 4'h0);
    maxc = 0;
    repeat (40) @(negedge clk);
    chk(maxc == 3, "R10 unstrobed write ignored", maxc, 3);

    // R10: single byte merges
    wr(2'd2, 32'hFFFF_FF07, 4'h1);
    maxc = 0;
    repeat (40) @(negedge clk);
    chk(maxc == 7, "R10 byte merge", maxc, 7);
    max_on = 0;

    // R4: compare 2
    wr(2'd3, 32'd2, 4'hF);
    hits = 0; hits_bad = 0; cmp_win = 1;
    repeat (40) @(negedge clk);
    cmp_win = 0;
    chk(hits >= 4, "R4 toggles seen", hits, 4);
    chk(hits_bad == 0, "R4 toggle at compare", hits_bad, 0);

    // R8: update while running
    wr(2'd0, 32'h5, 4'hF);
    chk(count == 0, "R8 update while running", count, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule